// File: doc/BRIEF.md
# Paced-DMA Serial Transmit Channel

One channel of a dual asynchronous serial controller. Its transmitter takes bytes either from CPU writes to the transmit holding register or from a DMA controller. A DMA transfer is paced: the channel requests one byte, sends it, and waits for a full character time before it requests the next. A programmable down-counter stands in for the shift register. The channel also has a three-entry receive FIFO that is filled only through an internal loopback path, interrupt status and mask bits, and a sticky DMA-complete flag.

The CPU side is a four-address byte register port. Address 0 is the mode register, and loopback is selected when bits 7:6 equal 2'b10. Address 1 takes commands on write: bit 0 enables the transmitter, bit 1 disables it and wins over bit 0, and bit 2 clears the DMA-complete flag. A read of address 1 returns interrupt status. Address 2 is the transmit holding register on write and pops the receive FIFO on read. Address 3 takes the interrupt mask on write. A read of address 3 returns status: bit 0 RX ready, bit 1 FIFO full, bit 2 TX ready, bit 3 TX empty, bit 4 transmitter enabled, bit 5 DMA transfer armed, bit 6 DMA-complete flag. The interrupt status and mask bit positions depend on the port. The TX bit is bit 0 for port A and bit 4 for port B, and the RX bit is the bit directly above the TX bit. A DMA transfer is armed by a start pulse together with a length L, and it moves L+1 bytes. The type code is 0 for verify, 1 for device-to-memory and 2 for memory-to-device, and only type 2 transmits.

Top module: `sio_dma_chan`

## Requirements
- R1: After reset, status, interrupt status, DRQ, the line strobe, DMA done and both interrupt outputs are all zero.
- R2: An enable command sets TX ready and TX empty. A disable command clears both, stops the character timer, drops DRQ and disarms any DMA transfer without signalling completion.
- R3: A holding-register write with the transmitter enabled drives the byte onto `tx_byte` with `tx_strobe` high for one cycle after the write edge. It also clears TX ready, TX empty and the TX interrupt-status bit. With the transmitter disabled the write is ignored.
- R4: For a reload value N, TX ready returns N+1 clock edges after the edge that started the character. N=0 gives a one-cycle character time.
- R5: When a character time ends with no DMA byte to fetch, TX ready, TX empty and the TX interrupt-status bit (bit 0 for port A) are set.
- R6: `irq` is high exactly when (TX status bit, TX mask bit, transmitter enabled and TX ready are all set) or (RX status bit and RX mask bit are both set).
- R7: In an unmasked memory-to-device transfer, bytes go out in address order, one per character time, with consecutive strobes N+1 cycles apart. `dma_ptr` advances once per byte.
- R8: A transfer of length L sends L+1 bytes. `dma_done` pulses once, N+1 cycles after the last strobe. At that point the DMA-complete flag and TX ready are set and the armed bit is cleared.
- R9: DRQ is never high while `dma_masked` is high. A character time that ends while the channel is masked sets TX ready instead. Unmasking later resumes the transfer.
- R10: The transfer type is latched at the first byte, so a later change of `dma_type` has no effect. A transfer whose latched type is not memory-to-device takes one acknowledge, sends nothing and completes at once.
- R11: With mode bits 7:6 = 2'b10, a transmitted byte is pushed into the receive FIFO and sets RX ready and the RX interrupt-status bit (bit 1 for port A). `tx_strobe` stays low.
- R12: The FIFO holds three bytes and sets the full flag when the third byte is stored. Pushes are dropped while the full flag is set.
- R13: A read of address 2 returns the oldest byte and pops it. RX ready, full and the RX status bit clear only when the FIFO becomes empty.
- R14: Command bit 2 clears the DMA-complete flag and `dma_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| char_reload | input | TIME_W | Character-time reload value N |
| dma_start | input | 1 | Arms a DMA transfer |
| dma_len | input | CNT_W | Transfer length L (L+1 bytes) |
| dma_type | input | 2 | Transfer type code from the DMA mode field |
| dma_masked | input | 1 | DMA channel mask bit |
| dma_drq | output | 1 | Byte request to the DMA controller |
| dma_ack | input | 1 | Acknowledge; `dma_rdata` is valid with it |
| dma_rdata | input | 8 | Byte fetched by the DMA controller |
| dma_ptr | output | CNT_W | Offset of the next byte to fetch |
| dma_done | output | 1 | One-cycle end-of-transfer pulse (sets controller mask and status) |
| dma_irq | output | 1 | Sticky DMA-complete interrupt |
| tx_byte | output | 8 | Byte handed to the line |
| tx_strobe | output | 1 | One-cycle valid for `tx_byte` |
| irq | output | 1 | Channel interrupt |

## Verification
The bench measures the gap between DMA strobes and the gap from the last strobe to `dma_done`. A design that fetches on the edge after expiry, instead of during the expiring cycle, shows gaps of N+2 cycles. A design that completes when the count underflows reports completion one character time early. A masked channel is checked to raise TX ready and then resume, and a type change after the first byte is checked to have no effect. Loopback fills the FIFO beyond its depth and pops it partway. A design that clears the full flag on the first pop, or drops RX ready early, gives wrong flags or accepts a byte that should be dropped.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the paced serial channel.
// Assumes 2-bit register addresses and byte-wide data.
package sio_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_MASK = 2'd3;

    localparam int CMD_TX_ON   = 0;
    localparam int CMD_TX_OFF  = 1;
    localparam int CMD_CLR_DMA = 2;

    // Active transfer kind; NONE when no type has been latched yet.
    typedef enum logic [2:0] {
        DK_NONE   = 3'd0,
        DK_VERIFY = 3'd1,
        DK_WRITE  = 3'd2,
        DK_READ   = 3'd4
    } dma_kind_e;

    // Maps the controller's type code to a transfer kind.
    function automatic dma_kind_e kind_of(input logic [1:0] code);
        case (code)
            2'd0:    return DK_VERIFY;
            2'd1:    return DK_WRITE;
            2'd2:    return DK_READ;
            default: return DK_NONE;
        endcase
    endfunction
endpackage

// File: rtl/sio_char_timer.sv
`timescale 1ns/1ps
// Character-time counter standing in for the transmit shift register.
// A load runs busy for reload+1 cycles; expire marks the final busy cycle.
// A load in the expiring cycle restarts it back to back.
module sio_char_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cancel,
    input  logic [TIME_W-1:0] reload,
    output logic              busy,
    output logic              expire
);
    logic [TIME_W-1:0] cnt_q;

    assign expire = busy && (cnt_q == '0);

    // Counts down the current character; cancel wins, then load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (cancel) begin
            busy  <= 1'b0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= reload;
        end else if (expire) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sio_rx_fifo.sv
`timescale 1ns/1ps
// Small receive FIFO with a sticky full flag.
// Full sets when the write pointer reaches the read pointer; it and the
// ready flag clear only when a pop leaves the FIFO empty. Pushes are
// refused while full is set. Assumes push and pop never coincide.
module sio_rx_fifo #(
    parameter int DEPTH = 3,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          ready,
    output logic          full,
    output logic          drain
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic          push_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && !full;
    assign drain   = pop && ready && !push_ok && (step(rptr_q) == wptr_q);
    assign head    = mem_q[rptr_q];

    // Stores accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wptr_q] <= push_data;
    end

    // Moves the pointers and keeps the ready and full flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ready  <= 1'b0;
            full   <= 1'b0;
        end else begin
            if (push_ok) wptr_q <= step(wptr_q);
            if (pop && ready) rptr_q <= step(rptr_q);
            if (push_ok) ready <= 1'b1;
            else if (drain) ready <= 1'b0;
            if (drain) full <= 1'b0;
            else if (push_ok && step(wptr_q) == rptr_q) full <= 1'b1;
        end
    end
endmodule

// File: rtl/sio_tx_pacer.sv
`timescale 1ns/1ps
// DMA pacing for the transmitter: one byte per character time.
// DRQ is raised when a byte is owed and the line is idle or just
// finishing; the type is latched on the first acknowledge. A transfer
// completes when the character of its last byte expires.
module sio_tx_pacer
    import sio_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic [1:0]       xfer_type,
    input  logic             ack,
    input  logic             cancel,
    input  logic             fetch_ok,
    input  logic             tx_busy,
    input  logic             tx_expire,
    output logic             drq,
    output logic             take,
    output logic             pending,
    output logic             done,
    output logic             armed,
    output logic [CNT_W-1:0] ptr
);
    dma_kind_e      kind_q, eff_kind;
    logic [CNT_W:0] rem_q;
    logic           hit;

    assign pending  = armed && !rem_q[CNT_W];
    assign drq      = pending && fetch_ok && (!tx_busy || tx_expire);
    assign hit      = drq && ack;
    assign eff_kind = (kind_q == DK_NONE) ? kind_of(xfer_type) : kind_q;
    assign take     = hit && (eff_kind == DK_READ);

    // Tracks the armed transfer, its remaining count and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            kind_q <= DK_NONE;
            rem_q  <= '0;
            ptr    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cancel) begin
                armed  <= 1'b0;
                kind_q <= DK_NONE;
            end else if (start) begin
                armed  <= 1'b1;
                kind_q <= DK_NONE;
                rem_q  <= {1'b0, len};
                ptr    <= '0;
            end else if (hit) begin
                if (eff_kind == DK_READ) begin
                    kind_q <= eff_kind;
                    ptr    <= ptr + 1'b1;
                    rem_q  <= rem_q - 1'b1;
                end else begin
                    armed  <= 1'b0;
                    kind_q <= DK_NONE;
                    done   <= 1'b1;
                end
            end else if (armed && rem_q[CNT_W] && tx_expire) begin
                armed  <= 1'b0;
                kind_q <= DK_NONE;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_dma_chan.sv
`timescale 1ns/1ps
// One serial channel with a DMA-paced transmitter, loopback into a
// three-entry receive FIFO, and interrupt status/mask bits.
// Assumes the DMA controller answers DRQ with ack and data in the same
// cycle, and that register reads and writes never coincide.
module sio_dma_chan
    import sio_pkg::*;
#(
    parameter bit PORT_B      = 1'b0,
    parameter int CNT_W       = 16,
    parameter int TIME_W      = 16,
    parameter int FIFO_DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [TIME_W-1:0] char_reload,
    input  logic              dma_start,
    input  logic [CNT_W-1:0]  dma_len,
    input  logic [1:0]        dma_type,
    input  logic              dma_masked,
    output logic              dma_drq,
    input  logic              dma_ack,
    input  logic [7:0]        dma_rdata,
    output logic [CNT_W-1:0]  dma_ptr,
    output logic              dma_done,
    output logic              dma_irq,
    output logic [7:0]        tx_byte,
    output logic              tx_strobe,
    output logic              irq
);
    localparam int TX_BIT = PORT_B ? 4 : 0;
    localparam int RX_BIT = TX_BIT + 1;

    logic [7:0] mode_q, imr_q, isr_q;
    logic       tx_en_q, txrdy_q, txemt_q, dma_flag_q;
    logic       wr_mode, wr_cmd, wr_thr, wr_imr, rd_rhr;
    logic       cmd_on, cmd_off, loopback, send, take, next_fetch, idle_set;
    logic       tmr_busy, tmr_expire, pend, armed;
    logic       fifo_rdy, fifo_full, fifo_drain;
    logic [7:0] send_byte, fifo_head;

    assign wr_mode  = reg_wr && reg_addr == ADDR_MODE;
    assign wr_cmd   = reg_wr && reg_addr == ADDR_CMD;
    assign wr_thr   = reg_wr && reg_addr == ADDR_DATA;
    assign wr_imr   = reg_wr && reg_addr == ADDR_MASK;
    assign rd_rhr   = reg_rd && reg_addr == ADDR_DATA;
    assign cmd_off  = wr_cmd && reg_wdata[CMD_TX_OFF];
    assign cmd_on   = wr_cmd && reg_wdata[CMD_TX_ON] && !reg_wdata[CMD_TX_OFF];
    assign loopback = mode_q[7:6] == 2'b10;

    assign send       = take || (wr_thr && tx_en_q);
    assign send_byte  = take ? dma_rdata : reg_wdata;
    assign next_fetch = pend && tx_en_q && !dma_masked;
    assign idle_set   = tmr_expire && !next_fetch && !send;

    sio_char_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(send), .cancel(cmd_off),
        .reload(char_reload), .busy(tmr_busy), .expire(tmr_expire)
    );

    sio_tx_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .start(dma_start), .len(dma_len),
        .xfer_type(dma_type), .ack(dma_ack), .cancel(cmd_off),
        .fetch_ok(tx_en_q && !dma_masked), .tx_busy(tmr_busy),
        .tx_expire(tmr_expire), .drq(dma_drq), .take(take), .pending(pend),
        .done(dma_done), .armed(armed), .ptr(dma_ptr)
    );

    sio_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(send && loopback), .push_data(send_byte),
        .pop(rd_rhr), .head(fifo_head), .ready(fifo_rdy), .full(fifo_full),
        .drain(fifo_drain)
    );

    // Holds mode and mask registers written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            imr_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata;
            if (wr_imr)  imr_q  <= reg_wdata;
        end
    end

    // Transmitter enable and the ready/empty flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
        end else if (cmd_off) begin
            tx_en_q <= 1'b0;
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
        end else if (cmd_on) begin
            tx_en_q <= 1'b1;
            txrdy_q <= 1'b1;
            txemt_q <= 1'b1;
        end else if (send) begin
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
        end else if (idle_set) begin
            txrdy_q <= 1'b1;
            txemt_q <= 1'b1;
        end
    end

    // Interrupt status bits for transmit and loopback receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            if (send) isr_q[TX_BIT] <= 1'b0;
            else if (idle_set) isr_q[TX_BIT] <= 1'b1;
            if (send && loopback) isr_q[RX_BIT] <= 1'b1;
            else if (fifo_drain) isr_q[RX_BIT] <= 1'b0;
        end
    end

    // Line output register and the sticky DMA-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte    <= '0;
            tx_strobe  <= 1'b0;
            dma_flag_q <= 1'b0;
        end else begin
            tx_strobe <= send && !loopback;
            if (send && !loopback) tx_byte <= send_byte;
            if (dma_done) dma_flag_q <= 1'b1;
            else if (wr_cmd && reg_wdata[CMD_CLR_DMA]) dma_flag_q <= 1'b0;
        end
    end

    // Read-data selection by address.
    always_comb begin
        case (reg_addr)
            ADDR_MODE: reg_rdata = mode_q;
            ADDR_CMD:  reg_rdata = isr_q;
            ADDR_DATA: reg_rdata = fifo_head;
            default:   reg_rdata = {1'b0, dma_flag_q, armed, tx_en_q,
                                    txemt_q, txrdy_q, fifo_full, fifo_rdy};
        endcase
    end

    assign dma_irq = dma_flag_q;
    assign irq = (isr_q[TX_BIT] && imr_q[TX_BIT] && tx_en_q && txrdy_q)
              || (isr_q[RX_BIT] && imr_q[RX_BIT]);
endmodule

// File: rtl/sio_dma_chan_chk.sv
`timescale 1ns/1ps
// Property checker for sio_dma_chan, attached with bind below.
module sio_dma_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dma_drq,
    input logic       dma_masked,
    input logic       send,
    input logic       loopback,
    input logic       cmd_wr,
    input logic       tx_strobe,
    input logic       txrdy,
    input logic       fifo_full,
    input logic       fifo_rdy,
    input logic       irq,
    input logic [7:0] isr,
    input logic [7:0] imr
);
    AST_DRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_drq |-> !dma_masked); // R9
    AST_LOOPBACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (send && loopback) |=> !tx_strobe); // R11
    AST_SEND_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !cmd_wr) |=> !txrdy); // R3
    AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_rdy); // R12
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((isr & imr) != 8'h00)); // R6
endmodule

bind sio_dma_chan sio_dma_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dma_drq(dma_drq), .dma_masked(dma_masked),
    .send(send), .loopback(loopback), .cmd_wr(wr_cmd), .tx_strobe(tx_strobe),
    .txrdy(txrdy_q), .fifo_full(fifo_full), .fifo_rdy(fifo_rdy), .irq(irq),
    .isr(isr_q), .imr(imr_q)
);

// File: tb/sio_dma_chan_bench.sv
`timescale 1ns/1ps
module sio_dma_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0, reg_rdata;
    logic [15:0] char_reload = 0;
    logic        dma_start = 0, dma_masked = 0, auto_ack = 1;
    logic [15:0] dma_len = 0, dma_ptr;
    logic [1:0]  dma_type = 2;
    logic        dma_drq, dma_ack, dma_done, dma_irq, tx_strobe, irq;
    logic [7:0]  dma_rdata, tx_byte;
    logic [7:0]  mem [16];

    int checks = 0, fails = 0, cyc = 0;
    int nstr = 0, ndone = 0, done_cyc = 0;
    logic [7:0] sbyte [16];
    int         scyc  [16];
    bit         finished = 0;

    assign dma_ack   = auto_ack && dma_drq;
    assign dma_rdata = mem[dma_ptr[3:0]];

    sio_dma_chan u_sio_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .char_reload(char_reload), .dma_start(dma_start), .dma_len(dma_len),
        .dma_type(dma_type), .dma_masked(dma_masked), .dma_drq(dma_drq),
        .dma_ack(dma_ack), .dma_rdata(dma_rdata), .dma_ptr(dma_ptr),
        .dma_done(dma_done), .dma_irq(dma_irq), .tx_byte(tx_byte),
        .tx_strobe(tx_strobe), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Logs line strobes and done pulses away from the active edge.
    always @(negedge clk) begin
        if (tx_strobe && nstr < 16) begin
            sbyte[nstr] = tx_byte;
            scyc[nstr]  = cyc;
            nstr++;
        end
        if (dma_done) begin
            ndone++;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic pop(output logic [7:0] v);
        reg_rd = 1; reg_addr = 2;
        #0.1;
        v = reg_rdata;
        @(posedge clk);
        #1;
        reg_rd = 0;
    endtask

    task automatic start_dma(input logic [15:0] len, input logic [1:0] typ);
        nstr = 0; ndone = 0;
        dma_len = len; dma_type = typ; dma_start = 1;
        @(posedge clk);
        #1;
        dma_start = 0;
    endtask

    task automatic wait_strobe();
        for (int i = 0; i < 50 && nstr == 0; i++) step(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3, v);
        chk(v == 8'h00, "R1 status", v, 0);
        peek(1, v);
        chk(v == 8'h00, "R1 isr", v, 0);
        chk({dma_drq, tx_strobe, dma_done, dma_irq, irq} == 5'b0, "R1 outputs",
            {dma_drq, tx_strobe, dma_done, dma_irq, irq}, 0);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(1, 8'h01);
        peek(3, v);
        chk(v == 8'h1C, "R2 enable flags", v, 8'h1C);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        char_reload = 3;
        wr(3, 8'h01);
        wr(2, 8'hA5);
        chk(tx_strobe && tx_byte == 8'hA5, "R3 strobe byte", tx_byte, 8'hA5);
        peek(3, v);
        chk(v == 8'h10, "R3 flags cleared", v, 8'h10);
        chk(irq == 0, "R6 irq low while busy", irq, 0);
        step(1);
        chk(tx_strobe == 0, "R3 one-cycle strobe", tx_strobe, 0);
        step(2);
        peek(3, v);
        chk(v[2] == 0, "R4 not ready at N edges", v[2], 0);
        step(1);
        peek(3, v);
        chk(v == 8'h1C, "R4 R5 ready at N+1 edges", v, 8'h1C);
        peek(1, v);
        chk(v == 8'h01, "R5 tx isr bit0", v, 1);
        chk(irq == 1, "R6 irq tx", irq, 1);
        wr(3, 8'h00);
        chk(irq == 0, "R6 irq masked", irq, 0);
        char_reload = 0;
        wr(2, 8'h3C);
        peek(3, v);
        chk(v[2] == 0, "R4 zero reload busy", v[2], 0);
        step(1);
        peek(3, v);
        chk(v[2] == 1, "R4 zero reload one cycle", v[2], 1);
        wr(1, 8'h02);
        peek(3, v);
        chk(v == 8'h00, "R2 disable clears", v, 0);
        wr(2, 8'h77);
        chk(tx_strobe == 0, "R3 write ignored when disabled", tx_strobe, 0);
        wr(1, 8'h01);
    endtask

    task automatic t_dma();
        logic [7:0] v;
        char_reload = 2;
        start_dma(16'd2, 2'd2);
        step(20);
        chk(nstr == 3, "R8 byte count", nstr, 3);
        for (int i = 0; i < 3; i++)
            chk(sbyte[i] == mem[i], "R7 byte order", sbyte[i], mem[i]);
        chk(scyc[1] - scyc[0] == 3, "R7 spacing 1", scyc[1] - scyc[0], 3);
        chk(scyc[2] - scyc[1] == 3, "R7 spacing 2", scyc[2] - scyc[1], 3);
        chk(dma_ptr == 16'd3, "R7 pointer", dma_ptr, 3);
        chk(ndone == 1, "R8 done once", ndone, 1);
        chk(done_cyc - scyc[2] == 3, "R8 done after last char", done_cyc - scyc[2], 3);
        peek(3, v);
        chk(v == 8'h5C, "R8 status after done", v, 8'h5C);
        chk(dma_irq == 1, "R8 dma irq", dma_irq, 1);
        wr(1, 8'h04);
        peek(3, v);
        chk(v == 8'h1C && dma_irq == 0, "R14 flag cleared", v, 8'h1C);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        char_reload = 4;
        dma_masked = 1;
        start_dma(16'd1, 2'd2);
        step(5);
        chk(dma_drq == 0 && nstr == 0, "R9 masked no drq", nstr, 0);
        dma_masked = 0;
        wait_strobe();
        dma_masked = 1;
        step(8);
        peek(3, v);
        chk(v[2] == 1 && nstr == 1, "R9 ready while masked", {v[2], nstr[3:0]}, 5'h11);
        chk(dma_drq == 0, "R9 drq held off", dma_drq, 0);
        dma_masked = 0;
        step(12);
        chk(nstr == 2 && ndone == 1, "R9 resumes", nstr, 2);
        wr(1, 8'h04);
    endtask

    task automatic t_type();
        logic [7:0] v;
        char_reload = 2;
        start_dma(16'd1, 2'd2);
        wait_strobe();
        dma_type = 2'd1;
        step(12);
        chk(nstr == 2 && ndone == 1, "R10 type latched", nstr, 2);
        start_dma(16'd3, 2'd1);
        step(4);
        peek(3, v);
        chk(nstr == 0 && ndone == 1 && v[5] == 0, "R10 non-read ends", nstr, 0);
        wr(1, 8'h04);
    endtask

    task automatic t_cancel();
        logic [7:0] v;
        char_reload = 4;
        start_dma(16'd5, 2'd2);
        wait_strobe();
        wr(1, 8'h02);
        step(12);
        peek(3, v);
        chk(nstr == 1 && ndone == 0, "R2 cancel no done", ndone, 0);
        chk(dma_drq == 0 && (v & 8'h3C) == 0, "R2 cancel flags", v, 0);
        wr(1, 8'h01);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        char_reload = 0;
        nstr = 0;
        wr(0, 8'h80);
        wr(3, 8'h02);
        wr(2, 8'h11);
        chk(tx_strobe == 0, "R11 no line output", tx_strobe, 0);
        peek(3, v);
        chk(v[0] == 1, "R11 rx ready", v[0], 1);
        peek(1, v);
        chk(v[1] == 1 && irq == 1, "R11 rx isr bit1", v, 2);
        wr(2, 8'h22);
        peek(3, v);
        chk(v[1] == 0, "R12 not full at two", v[1], 0);
        wr(2, 8'h33);
        peek(3, v);
        chk(v[1] == 1, "R12 full at three", v[1], 1);
        wr(2, 8'h44);
        pop(v);
        chk(v == 8'h11, "R13 oldest first", v, 8'h11);
        peek(3, v);
        chk(v[1:0] == 2'b11 && irq == 1, "R13 flags held", v[1:0], 3);
        wr(2, 8'h55);
        pop(v);
        chk(v == 8'h22, "R12 push dropped while full", v, 8'h22);
        pop(v);
        chk(v == 8'h33, "R12 third byte", v, 8'h33);
        peek(3, v);
        chk(v[1:0] == 2'b00, "R13 flags clear on empty", v[1:0], 0);
        peek(1, v);
        chk(v[1] == 0 && irq == 0, "R13 rx isr clear", v, 0);
        chk(nstr == 0, "R11 no strobes in loopback", nstr, 0);
        wr(0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h40 + 8'(i);
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_enable();
        t_tx();
        t_dma();
        t_mask();
        t_type();
        t_cancel();
        t_loop();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule